// File: doc/BRIEF.md
# Multi-Code PCM Line Encoder

This block turns a serial NRZ-L bit stream into one of ten PCM line codes for the output of a test-signal generator. The code is picked at run time through a 4-bit select field out of a space of sixteen values: three NRZ variants, three bi-phase variants, and randomized NRZ built on self-synchronizing scramblers of 11, 15, 17 or 23 stages. A zero-degree clock comes out next to the encoded line. Its falling edge marks the start of each bit cell and its rising edge marks the middle.

Timing comes from a clock enable `half_en` that pulses twice per bit period. A small state machine steps through its states on each pulse. `ST_IDLE` is the state after reset, before the first pulse. `ST_FIRST` means the first half of a bit cell is being driven. `ST_SECOND` means the second half is being driven. There are three transitions: `ST_IDLE -> ST_FIRST` on the first pulse, `ST_FIRST -> ST_SECOND` on a mid-bit pulse, and `ST_SECOND -> ST_FIRST` on the next bit-start pulse. On every bit-start pulse the block samples the data bit and the code select, works out both half-cell levels, and updates the running level used by the mark and space codes. On a scrambled code it also advances the scrambler. The mid-bit pulse only presents the second-half level that was stored at bit start.

Top module: `pcm_line_encoder`

## Requirements
- R1: Reset (active-low `rst_n`) drives `line_out` and `clk_out` to 0, clears the running mark/space level to 0 and clears every scrambler stage to 0.
- R2: The outputs change only on a clock edge where `half_en` is 1. A bit-start pulse drives `clk_out` to 0. A mid-bit pulse drives `clk_out` to 1.
- R3: Code 0 (NRZ-L) and the unused codes 10 through 15 drive the data bit for the whole cell.
- R4: Code 1 (NRZ-M) inverts the running level at the start of a 1 bit and holds it for a 0 bit. The running level is driven for the whole cell.
- R5: Code 2 (NRZ-S) inverts the running level at the start of a 0 bit and holds it for a 1 bit. The running level is driven for the whole cell.
- R6: Code 3 (Bi-phase-L) drives a 1 as high then low, and a 0 as low then high.
- R7: Code 4 (Bi-phase-M) inverts the running level at every bit start, and inverts it again at mid-bit when the bit is 1.
- R8: Code 5 (Bi-phase-S) inverts the running level at every bit start, and inverts it again at mid-bit when the bit is 0.
- R9: Codes 6, 7, 8 and 9 select randomized NRZ with 11, 15, 17 and 23 stages. The feedback taps are (11,9), (15,14), (17,14) and (23,18). The line bit is the data bit XOR the two line bits sent that many bit times earlier, and it is held for the whole cell.
- R10: `data_in` and `code_sel` are sampled only on a bit-start pulse. A change at mid-bit has no effect on the second half of the current cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | Enable that pulses at twice the bit rate |
| data_in | input | 1 | NRZ-L data bit, sampled at bit start |
| code_sel | input | 4 | Line code select, sampled at bit start |
| line_out | output | 1 | Encoded line level |
| clk_out | output | 1 | Zero-degree clock: low in the first half-cell, high in the second |

## Verification
The hardest case to reach from the ports is a code or data change that lands exactly on a mid-bit pulse. That change must leave the current cell alone and take effect only from the next bit start. The bench reaches it with a bit-send task that swaps `code_sel` and `data_in` to contrasting values between the two pulses of one cell, for example Bi-phase-L with a 1 bit swapped to NRZ-L. It then checks that the second half still shows the inverted level of the original code. The scrambled codes need a history of earlier line bits before their taps matter, so each scrambler length gets a run of more than 23 bits, followed by a reset that shows the history has been cleared.

// File: rtl/pcm_enc_pkg.sv
package pcm_enc_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } enc_state_e;

    localparam logic [CODE_W-1:0] CD_NRZL = 4'd0;
    localparam logic [CODE_W-1:0] CD_NRZM = 4'd1;
    localparam logic [CODE_W-1:0] CD_NRZS = 4'd2;
    localparam logic [CODE_W-1:0] CD_BIPL = 4'd3;
    localparam logic [CODE_W-1:0] CD_BIPM = 4'd4;
    localparam logic [CODE_W-1:0] CD_BIPS = 4'd5;
    localparam logic [CODE_W-1:0] CD_RN11 = 4'd6;
    localparam logic [CODE_W-1:0] CD_RN23 = 4'd9;

    // true for the four randomized NRZ selections
    function automatic logic is_rand(input logic [CODE_W-1:0] sel);
        return (sel >= CD_RN11) && (sel <= CD_RN23);
    endfunction

    // 0..3 index of the scrambler length for codes 6..9
    function automatic logic [1:0] rand_idx(input logic [CODE_W-1:0] sel);
        return sel[1:0] - 2'd2;
    endfunction

    // longest feedback tap (equals the register length)
    function automatic int tap_far(input logic [1:0] idx);
        case (idx)
            2'd0:    return 11;
            2'd1:    return 15;
            2'd2:    return 17;
            default: return 23;
        endcase
    endfunction

    // second feedback tap
    function automatic int tap_near(input logic [1:0] idx);
        case (idx)
            2'd0:    return 9;
            2'd1:    return 14;
            2'd2:    return 14;
            default: return 18;
        endcase
    endfunction

endpackage

// File: rtl/pcm_enc_scrambler.sv
module pcm_enc_scrambler
    import pcm_enc_pkg::*;
#(
    parameter int MAX_LEN = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic [1:0] len_idx,
    input  logic       din,
    output logic       dout
);

    // hist[k] holds the line bit sent k+1 bit times ago
    logic [MAX_LEN-1:0] hist;
    logic [MAX_LEN-1:0] tap_mask;

    always_comb begin
        for (int i = 0; i < MAX_LEN; i++) begin
            tap_mask[i] = (i == tap_far(len_idx) - 1) || (i == tap_near(len_idx) - 1);
        end
    end

    assign dout = din ^ (^(hist & tap_mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (step) begin
            hist <= {hist[MAX_LEN-2:0], dout};
        end
    end

endmodule

// File: rtl/pcm_enc_symbol.sv
module pcm_enc_symbol
    import pcm_enc_pkg::*;
(
    input  logic [CODE_W-1:0] sel,
    input  logic              din,
    input  logic              lvl,
    input  logic              scr_bit,
    output logic              half1,
    output logic              half2,
    output logic              lvl_next
);

    logic flip;

    always_comb begin
        flip     = ~lvl;
        half1    = din;
        half2    = din;
        lvl_next = lvl;
        unique case (sel)
            CD_NRZM: begin
                half1    = lvl ^ din;
                half2    = lvl ^ din;
                lvl_next = lvl ^ din;
            end
            CD_NRZS: begin
                half1    = lvl ^ ~din;
                half2    = lvl ^ ~din;
                lvl_next = lvl ^ ~din;
            end
            CD_BIPL: begin
                half1 = din;
                half2 = ~din;
            end
            CD_BIPM: begin
                half1    = flip;
                half2    = flip ^ din;
                lvl_next = flip ^ din;
            end
            CD_BIPS: begin
                half1    = flip;
                half2    = flip ^ ~din;
                lvl_next = flip ^ ~din;
            end
            default: begin
                if (is_rand(sel)) begin
                    half1 = scr_bit;
                    half2 = scr_bit;
                end
            end
        endcase
    end

endmodule

// File: rtl/pcm_line_encoder.sv
module pcm_line_encoder
    import pcm_enc_pkg::*;
#(
    parameter int SCR_MAX = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_en,
    input  logic              data_in,
    input  logic [CODE_W-1:0] code_sel,
    output logic              line_out,
    output logic              clk_out
);

    enc_state_e state_q;
    enc_state_e state_d;

    logic line_q;
    logic clk_q;
    logic half2_q;
    logic lvl_q;
    logic bit_start;
    logic scr_bit;
    logic sym_h1;
    logic sym_h2;
    logic sym_lvl;

    assign bit_start = half_en && (state_q != ST_FIRST);

    pcm_enc_scrambler #(.MAX_LEN(SCR_MAX)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (bit_start && is_rand(code_sel)),
        .len_idx (rand_idx(code_sel)),
        .din     (data_in),
        .dout    (scr_bit)
    );

    pcm_enc_symbol u_sym (
        .sel      (code_sel),
        .din      (data_in),
        .lvl      (lvl_q),
        .scr_bit  (scr_bit),
        .half1    (sym_h1),
        .half2    (sym_h2),
        .lvl_next (sym_lvl)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (half_en) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_FIRST;
                ST_FIRST:  state_d = ST_SECOND;
                ST_SECOND: state_d = ST_FIRST;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output and cell registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            clk_q   <= 1'b0;
            half2_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else if (half_en) begin
            unique case (state_q)
                ST_FIRST: begin
                    line_q <= half2_q;
                    clk_q  <= 1'b1;
                end
                default: begin
                    line_q  <= sym_h1;
                    clk_q   <= 1'b0;
                    half2_q <= sym_h2;
                    lvl_q   <= sym_lvl;
                end
            endcase
        end
    end

    assign line_out = line_q;
    assign clk_out  = clk_q;

endmodule

// File: rtl/pcm_line_encoder_chk.sv
module pcm_line_encoder_chk
    import pcm_enc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              half_en,
    input logic [CODE_W-1:0] code_sel,
    input logic              line_out,
    input logic              clk_out,
    input enc_state_e        state
);

    logic [CODE_W-1:0] cell_code;
    logic              flat_code;
    logic              bi_ms_cell;
    logic              bi_ms_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_code <= '0;
        end else if (half_en && state != ST_FIRST) begin
            cell_code <= code_sel;
        end
    end

    assign flat_code  = (cell_code != CD_BIPL) && (cell_code != CD_BIPM) && (cell_code != CD_BIPS);
    assign bi_ms_cell = (cell_code == CD_BIPM) || (cell_code == CD_BIPS);
    assign bi_ms_sel  = (code_sel == CD_BIPM) || (code_sel == CD_BIPS);

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !half_en |=> ($stable(line_out) && $stable(clk_out))); // R2

    AST_CLK_HIGH_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && state == ST_FIRST) |=> clk_out); // R2

    AST_CLK_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && state != ST_FIRST) |=> !clk_out); // R2

    AST_FLAT_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && state == ST_FIRST && flat_code) |=> $stable(line_out)); // R3

    AST_BIPL_MID_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && state == ST_FIRST && cell_code == CD_BIPL) |=> (line_out != $past(line_out))); // R6

    AST_BIMS_EDGE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && state == ST_SECOND && bi_ms_cell && bi_ms_sel) |=> (line_out != $past(line_out))); // R7

endmodule

bind pcm_line_encoder pcm_line_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_en  (half_en),
    .code_sel (code_sel),
    .line_out (line_out),
    .clk_out  (clk_out),
    .state    (state_q)
);

// File: tb/pcm_line_encoder_bench.sv
`timescale 1ns/1ps
module pcm_line_encoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_en = 1'b0;
    logic       data_in = 1'b0;
    logic [3:0] code_sel = 4'd0;
    logic       line_out;
    logic       clk_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench reference state
    logic        m_lvl = 1'b0;
    logic [22:0] m_hist = '0;

    always #4 clk = ~clk;

    pcm_line_encoder u_pcm_line_encoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_en  (half_en),
        .data_in  (data_in),
        .code_sel (code_sel),
        .line_out (line_out),
        .clk_out  (clk_out)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        half_en = 1'b0;
        repeat (3) @(negedge clk);
        m_lvl = 1'b0;
        m_hist = '0;
        chk("R1 line after reset", line_out, 1'b0);
        chk("R1 clk after reset", clk_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive one bit cell; the mid values are applied between the two pulses
    task automatic send_bit(input logic d, input logic [3:0] code,
                            input logic d_mid, input logic [3:0] code_mid,
                            input string tag);
        logic e1, e2, fb;
        int a, b;
        e1 = d;
        e2 = d;
        case (code)
            4'd1: begin m_lvl = m_lvl ^ d; e1 = m_lvl; e2 = m_lvl; end
            4'd2: begin m_lvl = m_lvl ^ !d; e1 = m_lvl; e2 = m_lvl; end
            4'd3: begin e1 = d; e2 = !d; end
            4'd4: begin e1 = !m_lvl; e2 = d ? m_lvl : !m_lvl; m_lvl = e2; end
            4'd5: begin e1 = !m_lvl; e2 = d ? !m_lvl : m_lvl; m_lvl = e2; end
            4'd6, 4'd7, 4'd8, 4'd9: begin
                a = (code == 4'd6) ? 11 : (code == 4'd7) ? 15 : (code == 4'd8) ? 17 : 23;
                b = (code == 4'd6) ? 9 : (code == 4'd9) ? 18 : 14;
                fb = d ^ m_hist[a-1] ^ m_hist[b-1];
                m_hist = {m_hist[21:0], fb};
                e1 = fb;
                e2 = fb;
            end
            default: begin e1 = d; e2 = d; end
        endcase
        @(negedge clk);
        data_in = d;
        code_sel = code;
        half_en = 1'b1;
        @(negedge clk);
        half_en = 1'b0;
        chk({tag, " first half"}, line_out, e1);
        chk({tag, " clk low in first half"}, clk_out, 1'b0);
        data_in = d_mid;
        code_sel = code_mid;
        @(negedge clk);
        half_en = 1'b1;
        @(negedge clk);
        half_en = 1'b0;
        chk({tag, " second half"}, line_out, e2);
        chk({tag, " clk high in second half"}, clk_out, 1'b1);
    endtask

    task automatic run_code(input logic [3:0] code, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic d;
            d = (i[0] ^ i[2]) | (i[3] & i[1]);
            send_bit(d, code, d, code, tag);
        end
    endtask

    task automatic t_nrz_level();
        run_code(4'd0, 12, "R3 NRZ-L");
        for (int c = 10; c < 16; c++) begin
            send_bit(1'b1, 4'(c), 1'b1, 4'(c), "R3 unused code");
            send_bit(1'b0, 4'(c), 1'b0, 4'(c), "R3 unused code");
        end
    endtask

    task automatic t_nrz_mark();
        run_code(4'd1, 16, "R4 NRZ-M");
    endtask

    task automatic t_nrz_space();
        run_code(4'd2, 16, "R5 NRZ-S");
    endtask

    task automatic t_biph_level();
        run_code(4'd3, 12, "R6 Bi-phase-L");
    endtask

    task automatic t_biph_mark();
        run_code(4'd4, 16, "R7 Bi-phase-M");
    endtask

    task automatic t_biph_space();
        run_code(4'd5, 16, "R8 Bi-phase-S");
    endtask

    task automatic t_rand();
        run_code(4'd6, 40, "R9 RNRZ-11");
        run_code(4'd7, 40, "R9 RNRZ-15");
        run_code(4'd8, 40, "R9 RNRZ-17");
        run_code(4'd9, 48, "R9 RNRZ-23");
    endtask

    task automatic t_mid_change();
        send_bit(1'b1, 4'd3, 1'b1, 4'd0, "R10 Bi-phase-L to NRZ-L at mid");
        send_bit(1'b0, 4'd0, 1'b1, 4'd3, "R10 NRZ-L data flip at mid");
        send_bit(1'b1, 4'd4, 1'b0, 4'd1, "R10 Bi-phase-M to NRZ-M at mid");
        send_bit(1'b0, 4'd1, 1'b1, 4'd5, "R10 NRZ-M to Bi-phase-S at mid");
        send_bit(1'b1, 4'd7, 1'b0, 4'd3, "R10 RNRZ-15 to Bi-phase-L at mid");
    endtask

    task automatic t_hold();
        logic l0, c0;
        send_bit(1'b1, 4'd3, 1'b1, 4'd3, "R2 hold lead-in");
        l0 = line_out;
        c0 = clk_out;
        for (int i = 0; i < 5; i++) begin
            data_in = ~data_in;
            code_sel = 4'(i);
            @(negedge clk);
            chk("R2 line holds without enable", line_out, l0);
            chk("R2 clk holds without enable", clk_out, c0);
        end
    endtask

    task automatic t_reset_clears();
        send_bit(1'b1, 4'd1, 1'b1, 4'd1, "R4 set level");
        run_code(4'd9, 30, "R9 fill history");
        apply_reset();
        send_bit(1'b0, 4'd1, 1'b0, 4'd1, "R1 level cleared");
        send_bit(1'b0, 4'd9, 1'b0, 4'd9, "R1 scrambler cleared");
        send_bit(1'b1, 4'd9, 1'b1, 4'd9, "R1 scrambler cleared");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        apply_reset();
        t_nrz_level();
        t_nrz_mark();
        t_nrz_space();
        t_biph_level();
        t_biph_mark();
        t_biph_space();
        t_rand();
        t_mid_change();
        t_hold();
        t_reset_clears();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule